// File: doc/BRIEF.md
# Receive Error-Bit Policy Controller

This block sits behind the waveform checker of a single-wire serial receiver. It takes the checker's error pulses and decides two things. The first is whether the message being received is abandoned. The second is whether the node pulls the shared line low for an error bit, which tells the sender that its frame was damaged. There are three error pulses: a rising edge that came too early, a bit period that was too short, and a bit period that was too long.

The decision depends on five static configuration bits and on whether the current message is addressed to all nodes. Messages to a single node follow the per-error generate options. For broadcast messages there is a separate rule set, and one option can silence error bits for broadcast messages entirely. When an error bit is issued, the line-pull output is held for one and a half nominal bit periods. That length is counted in sub-bit ticks from the bit timer. Each error kind also leaves a sticky flag, which is cleared by writing a 1 to it.

Top module: `rx_errbit_policy`

## Requirements
- R1: After reset, `rx_abort` and `bus_low` are 0 and `err_flags` is 3'b000.
- R2: `rx_abort` pulses high for exactly one cycle, in the cycle after the error is sampled. A rising-edge error causes the pulse only when `cfg_stop_on_rise` is 1. A short-period or long-period error always causes it.
- R3: For a message to a single node (`bcast`=0), a rising-edge error starts an error bit only when both `cfg_stop_on_rise` and `cfg_rise_gen` are 1.
- R4: For a message to a single node, a long-period error starts an error bit only when `cfg_long_gen` is 1.
- R5: For a broadcast message with `cfg_bcast_quiet`=0, a rising-edge error starts an error bit only when `cfg_stop_on_rise` is 1 and `cfg_rise_gen` is 0.
- R6: For a broadcast message with `cfg_bcast_quiet`=0, a long-period error starts an error bit only when `cfg_long_gen` is 0.
- R7: For a broadcast message with `cfg_bcast_quiet`=1, no error of any kind starts an error bit.
- R8: A short-period error starts an error bit unless the message is broadcast and either `cfg_full_listen` or `cfg_bcast_quiet` is 1.
- R9: `bus_low` rises in the cycle after the triggering error is sampled. It stays high while PULSE_TICKS `bit_tick` pulses are counted, where PULSE_TICKS = TICKS_PER_BIT*3/2 (15 by default). It falls in the cycle after the last of those ticks.
- R10: An error sampled while `bus_low` is high neither restarts nor extends the error bit, but it still sets its flag and can still cause an abort.
- R11: `err_flags` bit 0 is set by a rising-edge error, bit 1 by a short-period error and bit 2 by a long-period error. A flag stays set until a 1 is written to the same bit of `flag_clr`. If an error and a clear reach the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_stop_on_rise | input | 1 | Abandon the message on a rising-edge error |
| cfg_rise_gen | input | 1 | Error-bit option for rising-edge errors |
| cfg_long_gen | input | 1 | Error-bit option for long-period errors |
| cfg_bcast_quiet | input | 1 | Suppress every error bit on broadcast messages |
| cfg_full_listen | input | 1 | Node also accepts traffic addressed to other nodes |
| bcast | input | 1 | Current message is broadcast |
| err_rise | input | 1 | Rising-edge error pulse |
| err_short | input | 1 | Short bit-period error pulse |
| err_long | input | 1 | Long bit-period error pulse |
| bit_tick | input | 1 | Sub-bit tick, TICKS_PER_BIT per nominal bit period |
| flag_clr | input | 3 | Write-one-to-clear for the sticky flags |
| rx_abort | output | 1 | One-cycle pulse: abandon the current reception |
| bus_low | output | 1 | Pull the line low (error bit in progress) |
| err_flags | output | 3 | Sticky flags {long, short, rise} |

## Verification
The assertions assume that the error inputs are single-cycle pulses and that `bit_tick` is never high two cycles in a row. They also assume that the configuration bits and `bcast` change only while no error pulse is present. The stimulus follows these assumptions. It raises each error pulse for one cycle, at a falling edge. It derives `bit_tick` from a counter that fires every third cycle. It changes configuration only between scenarios, once any error bit in progress has ended. A sweep covers every configuration, each error kind and both message types. Directed cases then fire errors in the middle of a pulse, at the same time as a clear, and together in a single cycle.

// File: rtl/rx_errbit_policy.sv
module rx_errbit_policy #(
  parameter int TICKS_PER_BIT = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_stop_on_rise,
  input  logic       cfg_rise_gen,
  input  logic       cfg_long_gen,
  input  logic       cfg_bcast_quiet,
  input  logic       cfg_full_listen,
  input  logic       bcast,
  input  logic       err_rise,
  input  logic       err_short,
  input  logic       err_long,
  input  logic       bit_tick,
  input  logic [2:0] flag_clr,
  output logic       rx_abort,
  output logic       bus_low,
  output logic [2:0] err_flags
);
  localparam int PULSE_TICKS = TICKS_PER_BIT * 3 / 2;
  localparam int CW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;

  logic [CW-1:0] tick_cnt;
  logic          rise_bit, long_bit, short_bit, want_bit, abort_n;

  assign rise_bit  = bcast ? (!cfg_bcast_quiet && cfg_stop_on_rise && !cfg_rise_gen)
                           : (cfg_stop_on_rise && cfg_rise_gen);
  assign long_bit  = bcast ? (!cfg_bcast_quiet && !cfg_long_gen) : cfg_long_gen;
  assign short_bit = !(bcast && (cfg_bcast_quiet || cfg_full_listen));
  assign want_bit  = (err_rise && rise_bit) || (err_long && long_bit) || (err_short && short_bit);
  assign abort_n   = (err_rise && cfg_stop_on_rise) || err_short || err_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_abort  <= 1'b0;
      err_flags <= 3'b000;
    end else begin
      rx_abort  <= abort_n;
      err_flags <= (err_flags & ~flag_clr) | {err_long, err_short, err_rise};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_low  <= 1'b0;
      tick_cnt <= '0;
    end else if (bus_low) begin
      if (bit_tick) begin
        if (tick_cnt == CW'(PULSE_TICKS - 1)) bus_low <= 1'b0;
        else tick_cnt <= tick_cnt + 1'b1;
      end
    end else if (want_bit) begin
      bus_low  <= 1'b1;
      tick_cnt <= '0;
    end
  end

  // R2
  abort_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rise && cfg_stop_on_rise) |=> rx_abort);

  // R7
  bcast_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast && cfg_bcast_quiet && !bus_low) |=> !bus_low);

  // R9
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_low) |-> $past(bit_tick));

  // R9
  start_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_low) |-> $past(err_rise || err_short || err_long));

  // R10
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_low && !bit_tick) |=> bus_low);

  // R11
  long_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_long |=> err_flags[2]);
endmodule

// File: tb/rx_errbit_policy_test.sv
module rx_errbit_policy_test;
  localparam int P = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop = 0, rgen = 0, lgen = 0, quiet = 0, full = 0, bc = 0;
  logic er = 0, es = 0, el = 0, tick = 0;
  logic [2:0] clr = 3'b000;
  logic abort_o, low_o;
  logic [2:0] flags_o;

  int tests = 0, fails = 0, tcnt = 0;
  string cur_req = "R1";

  int m_abort = 0, m_low = 0, m_cnt = 0, m_flags = 0;

  always #2 clk = ~clk;

  rx_errbit_policy uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_stop_on_rise(stop), .cfg_rise_gen(rgen), .cfg_long_gen(lgen),
    .cfg_bcast_quiet(quiet), .cfg_full_listen(full), .bcast(bc),
    .err_rise(er), .err_short(es), .err_long(el), .bit_tick(tick),
    .flag_clr(clr), .rx_abort(abort_o), .bus_low(low_o), .err_flags(flags_o)
  );

  function automatic bit wants();
    bit r, l, s;
    if (bc) begin
      r = !quiet && stop && !rgen;
      l = !quiet && !lgen;
      s = !(quiet || full);
    end else begin
      r = stop && rgen;
      l = lgen;
      s = 1;
    end
    return (er && r) || (el && l) || (es && s);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_abort = 0; m_low = 0; m_cnt = 0; m_flags = 0;
    end else begin
      m_abort = ((er && stop) || es || el) ? 1 : 0;
      m_flags = (m_flags & ~int'(clr)) | (el << 2) | (es << 1) | int'(er);
      if (m_low != 0) begin
        if (tick) begin
          m_cnt++;
          if (m_cnt == P) m_low = 0;
        end
      end else if (wants()) begin
        m_low = 1;
        m_cnt = 0;
      end
    end
  end

  task automatic compare();
    tests++;
    if (int'(abort_o) != m_abort) begin
      fails++;
      $display("FAIL R2 rx_abort actual=%0d expected=%0d at %0t", abort_o, m_abort, $time);
    end
    if (int'(low_o) != m_low) begin
      fails++;
      $display("FAIL %s bus_low actual=%0d expected=%0d at %0t", cur_req, low_o, m_low, $time);
    end
    if (int'(flags_o) != m_flags) begin
      fails++;
      $display("FAIL R11 err_flags actual=%0d expected=%0d at %0t", flags_o, m_flags, $time);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      er = 0; es = 0; el = 0; clr = 3'b000;
      tick = (tcnt % 3 == 2);
      tcnt++;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tests++;
    if (abort_o !== 1'b0 || low_o !== 1'b0 || flags_o !== 3'b000) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b%b%b expected=000", abort_o, low_o, flags_o);
    end
    run(2);

    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < 3; k++) begin
          {stop, rgen, lgen, quiet, full} = 5'(cfg);
          bc = b[0];
          if (bc && quiet) cur_req = "R7";
          else if (k == 1) cur_req = "R8";
          else if (k == 0) cur_req = bc ? "R5" : "R3";
          else cur_req = bc ? "R6" : "R4";
          er = (k == 0); es = (k == 1); el = (k == 2);
          run(55);
          clr = 3'b111;
          run(1);
        end
      end
    end

    // R9 exact pulse length with single-node long error
    cur_req = "R9";
    {stop, rgen, lgen, quiet, full} = 5'b00100; bc = 0;
    el = 1; run(60);

    // R10 errors during an active pulse do not restart it
    cur_req = "R10";
    er = 1; stop = 1; rgen = 1; run(10);
    es = 1; run(10);
    el = 1; er = 1; run(30);
    run(30);

    // R11 set wins over same-cycle clear; clear of one bit only
    cur_req = "R11";
    {stop, rgen, lgen, quiet, full} = 5'b00010; bc = 1;
    es = 1; clr = 3'b010; run(3);
    er = 1; run(2);
    clr = 3'b001; run(3);
    clr = 3'b010; run(3);

    // R2 abort without error bit: rise error with stop clear does nothing
    cur_req = "R2";
    stop = 0; bc = 0; er = 1; run(3);
    stop = 1; er = 1; run(50);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule